// File: doc/BRIEF.md
# Acquire/Release Cache Maintenance Sequencer

This block sits between a stream of memory requests and the command port of an L1 data cache. It enforces memory-ordering semantics by sweeping the whole cache. It reads the ordering class of each request as plain, acquire, release, acquire-release, kernel begin or kernel end. On an acquire-type request it walks every block index and issues one invalidate command per block. On a release-type request it walks every block index and issues one flush command per block. An acquire-release request does the complete invalidate sweep first and the complete flush sweep after it.

Two counters track the commands still in flight, one for invalidates and one for writebacks. Completion pulses from the cache decrement them. Ordinary requests are held back while any writeback is outstanding; outstanding invalidates never hold anything back. Kernel-begin and kernel-end requests are still taken while writebacks drain. The context IDs of kernel-end requests wait in a small queue and are reported as finished, one per cycle and in arrival order, once the writeback count is zero and no sweep is running.

Top module: `l1_order_seq`

## Requirements
- R1: After reset, cmd_valid, done_valid and issue_stall are all 0, and no writebacks or invalidates are counted.
- R2: An acquire (req_kind 1) or kernel begin (req_kind 4) taken while no writebacks are outstanding starts a sweep. The sweep presents one invalidate command (cmd_op 0) for each index from 0 to NUM_BLOCKS-1 in ascending order. A command is presented on the cycle after the request is taken and advances once per cycle that cmd_ready is high. While cmd_ready is low the presented index and op hold steady.
- R3: A release (req_kind 2) sweeps every index with flush commands (cmd_op 1). Each flush handed over raises the writeback count.
- R4: An acquire-release (req_kind 3) presents all NUM_BLOCKS invalidate commands and then, on the very next cycle, all NUM_BLOCKS flush commands.
- R5: req_ready is 0 for every request kind while a sweep is in progress.
- R6: issue_stall is 1 exactly while the writeback count is nonzero. While it is 1, plain (0, 6, 7), acquire, release and acquire-release requests are refused. They are taken again once the count returns to zero.
- R7: While writebacks are outstanding, a kernel begin is still taken. It starts an invalidate sweep only if the invalidate count is zero; otherwise it causes no command.
- R8: A kernel end (req_kind 5) queues its req_ctx. If no writebacks are outstanding it also starts a flush sweep. If writebacks are outstanding it is taken without any sweep.
- R9: Queued kernel-end contexts are reported on done_valid/done_ctx, one per cycle in arrival order, whenever the writeback count is zero and no sweep runs. Outstanding invalidates do not delay these reports.
- R10: With invalidates outstanding and no writebacks outstanding, issue_stall stays 0 and plain requests are taken.
- R11: Each wb_done or inv_done pulse lowers its count by one. A command handed over in the same cycle as a completion of the same kind leaves the count unchanged. A completion arriving with a zero count is a protocol error.
- R12: Kernel-end requests are refused while the context queue holds KEND_DEPTH entries.
- R13: Requests that would start an invalidate sweep are refused while the invalidate count exceeds NUM_BLOCKS, so the count never exceeds 2*NUM_BLOCKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when also valid |
| req_kind | input | 3 | Ordering class: 0 plain, 1 acquire, 2 release, 3 acquire-release, 4 kernel begin, 5 kernel end, 6/7 plain |
| req_ctx | input | CTX_W | Context ID of the request |
| cmd_valid | output | 1 | Maintenance command present |
| cmd_ready | input | 1 | Cache takes the command |
| cmd_idx | output | IDX_W | Block index of the command |
| cmd_op | output | 1 | 0 invalidate, 1 flush |
| wb_done | input | 1 | One writeback completed |
| inv_done | input | 1 | One invalidate completed |
| done_valid | output | 1 | Kernel-end completion reported |
| done_ctx | output | CTX_W | Context ID of the completed kernel end |
| issue_stall | output | 1 | Writebacks outstanding |

## Verification
A request is taken at the clock edge where req_valid and req_ready are both high. The first command of its sweep is visible from the following cycle and advances one index per cycle while cmd_ready is high. issue_stall changes one cycle after the flush handshake or completion pulse that moves the writeback count to or from zero. A done report appears in that same cycle and the next report follows one cycle later. The bench drives inputs just after the falling edge and samples outputs shortly after it, so each check reads the registered state left by the preceding rising edge. Hidden counts are inferred from how many completion pulses it takes for issue_stall or req_ready to change.

// File: rtl/l1seq_pkg.sv
package l1seq_pkg;

    typedef enum logic [2:0] {
        RK_PLAIN  = 3'd0,
        RK_ACQ    = 3'd1,
        RK_REL    = 3'd2,
        RK_ACQREL = 3'd3,
        RK_KBEGIN = 3'd4,
        RK_KEND   = 3'd5
    } req_kind_e;

    localparam logic OP_INVAL = 1'b0;
    localparam logic OP_FLUSH = 1'b1;

endpackage

// File: rtl/l1seq_walker.sv
module l1seq_walker #(
    parameter int NUM_BLOCKS = 8,
    parameter int IDX_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_op,
    input  logic             start_chain,
    input  logic             cmd_ready,
    output logic             cmd_valid,
    output logic [IDX_W-1:0] cmd_idx,
    output logic             cmd_op,
    output logic             busy,
    output logic             fire
);
    import l1seq_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLOCKS - 1);

    typedef struct packed {
        logic             busy;
        logic             op;
        logic             chain;
        logic [IDX_W-1:0] idx;
    } walk_t;

    walk_t walk_d, walk_q;

    always_comb begin
        walk_d = walk_q;
        fire   = walk_q.busy && cmd_ready;
        if (!walk_q.busy) begin
            if (start) begin
                walk_d.busy  = 1'b1;
                walk_d.op    = start_op;
                walk_d.chain = start_chain;
                walk_d.idx   = '0;
            end
        end else if (fire) begin
            if (walk_q.idx == LAST_IDX) begin
                if (walk_q.chain) begin
                    // invalidate sweep finished, flush sweep follows at once
                    walk_d.op    = OP_FLUSH;
                    walk_d.chain = 1'b0;
                    walk_d.idx   = '0;
                end else begin
                    walk_d.busy = 1'b0;
                end
            end else begin
                walk_d.idx = walk_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign cmd_valid = walk_q.busy;
    assign cmd_idx   = walk_q.idx;
    assign cmd_op    = walk_q.op;
    assign busy      = walk_q.busy;

    assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_idx) && $stable(cmd_op));

    assert_chain_to_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire && walk_q.chain && walk_q.idx == LAST_IDX
        |=> cmd_valid && cmd_op == OP_FLUSH && cmd_idx == '0);

endmodule

// File: rtl/l1seq_outstanding.sv
module l1seq_outstanding #(
    parameter int CNT_W = 5,
    parameter int LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             zero
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec)      cnt_d.count = cnt_q.count + 1'b1;
        else if (dec && !inc) cnt_d.count = cnt_q.count - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q.count;
    assign zero  = (cnt_q.count == '0);

    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dec && !inc |-> count != '0);

    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !dec |-> count != CNT_W'(LIMIT));

endmodule

// File: rtl/l1seq_ctx_fifo.sv
module l1seq_ctx_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              nonempty,
    output logic              full,
    output logic [DATA_W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] slot;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             used;
    } fifo_t;

    fifo_t fifo_d, fifo_q;

    always_comb begin
        fifo_d = fifo_q;
        if (push) begin
            fifo_d.slot[fifo_q.wr] = push_data;
            fifo_d.wr = (fifo_q.wr == LAST_PTR) ? '0 : fifo_q.wr + 1'b1;
        end
        if (pop) begin
            fifo_d.rd = (fifo_q.rd == LAST_PTR) ? '0 : fifo_q.rd + 1'b1;
        end
        if (push && !pop)      fifo_d.used = fifo_q.used + 1'b1;
        else if (pop && !push) fifo_d.used = fifo_q.used - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    assign nonempty = (fifo_q.used != '0);
    assign full     = (fifo_q.used == CNT_W'(DEPTH));
    assign head     = fifo_q.slot[fifo_q.rd];

    assert_push_not_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    assert_pop_not_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nonempty);

endmodule

// File: rtl/l1_order_seq.sv
module l1_order_seq #(
    parameter int NUM_BLOCKS = 8,
    parameter int CTX_W      = 4,
    parameter int KEND_DEPTH = 4,
    parameter int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_kind,
    input  logic [CTX_W-1:0] req_ctx,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [IDX_W-1:0] cmd_idx,
    output logic             cmd_op,
    input  logic             wb_done,
    input  logic             inv_done,
    output logic             done_valid,
    output logic [CTX_W-1:0] done_ctx,
    output logic             issue_stall
);
    import l1seq_pkg::*;

    localparam int CNT_LIMIT = 2 * NUM_BLOCKS;
    localparam int CNT_W     = $clog2(CNT_LIMIT + 1);
    localparam logic [CNT_W-1:0] INV_ROOM_MAX = CNT_W'(NUM_BLOCKS);

    typedef struct packed {
        logic ready;
        logic start;
        logic start_op;
        logic start_chain;
        logic push;
    } dec_t;

    logic             walk_busy, walk_fire;
    logic [CNT_W-1:0] wb_count, inv_count;
    logic             wb_zero, inv_zero, inv_room;
    logic             q_nonempty, q_full, q_pop;
    logic [CTX_W-1:0] q_head;
    logic             accept;
    dec_t             dec;

    assign inv_room = (inv_count <= INV_ROOM_MAX);

    // Request classification and sweep launch
    always_comb begin
        dec = '0;
        unique case (req_kind)
            RK_ACQ: begin
                dec.ready    = !walk_busy && wb_zero && inv_room;
                dec.start    = 1'b1;
                dec.start_op = OP_INVAL;
            end
            RK_REL: begin
                dec.ready    = !walk_busy && wb_zero;
                dec.start    = 1'b1;
                dec.start_op = OP_FLUSH;
            end
            RK_ACQREL: begin
                dec.ready       = !walk_busy && wb_zero && inv_room;
                dec.start       = 1'b1;
                dec.start_op    = OP_INVAL;
                dec.start_chain = 1'b1;
            end
            RK_KBEGIN: begin
                dec.ready    = !walk_busy && (!wb_zero || inv_room);
                dec.start    = wb_zero || inv_zero;
                dec.start_op = OP_INVAL;
            end
            RK_KEND: begin
                dec.ready    = !walk_busy && !q_full;
                dec.start    = wb_zero;
                dec.start_op = OP_FLUSH;
                dec.push     = 1'b1;
            end
            default: begin
                dec.ready = !walk_busy && wb_zero;
            end
        endcase
    end

    assign req_ready = dec.ready;
    assign accept    = req_valid && dec.ready;
    assign q_pop     = q_nonempty && wb_zero && !walk_busy;

    l1seq_walker #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .IDX_W      (IDX_W)
    ) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept && dec.start),
        .start_op    (dec.start_op),
        .start_chain (dec.start_chain),
        .cmd_ready   (cmd_ready),
        .cmd_valid   (cmd_valid),
        .cmd_idx     (cmd_idx),
        .cmd_op      (cmd_op),
        .busy        (walk_busy),
        .fire        (walk_fire)
    );

    l1seq_outstanding #(
        .CNT_W (CNT_W),
        .LIMIT (CNT_LIMIT)
    ) u_wb_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (walk_fire && cmd_op == OP_FLUSH),
        .dec   (wb_done),
        .count (wb_count),
        .zero  (wb_zero)
    );

    l1seq_outstanding #(
        .CNT_W (CNT_W),
        .LIMIT (CNT_LIMIT)
    ) u_inv_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (walk_fire && cmd_op == OP_INVAL),
        .dec   (inv_done),
        .count (inv_count),
        .zero  (inv_zero)
    );

    l1seq_ctx_fifo #(
        .DEPTH  (KEND_DEPTH),
        .DATA_W (CTX_W)
    ) u_kend_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept && dec.push),
        .push_data (req_ctx),
        .pop       (q_pop),
        .nonempty  (q_nonempty),
        .full      (q_full),
        .head      (q_head)
    );

    assign done_valid  = q_pop;
    assign done_ctx    = q_head;
    assign issue_stall = !wb_zero;

    assert_no_accept_in_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready);

    assert_stall_gates_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stall && req_valid && req_ready
        |-> req_kind == RK_KBEGIN || req_kind == RK_KEND);

    assert_kend_drain_no_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stall && req_valid && req_ready && req_kind == RK_KEND |=> !cmd_valid);

    assert_done_when_drained_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !issue_stall && !cmd_valid);

endmodule

// File: tb/test_l1_order_seq.sv
module test_l1_order_seq;

    localparam int NB    = 8;
    localparam int CW    = 4;
    localparam int DEPTH = 4;
    localparam int IW    = 3;

    localparam logic [2:0] K_PLAIN  = 3'd0;
    localparam logic [2:0] K_ACQ    = 3'd1;
    localparam logic [2:0] K_REL    = 3'd2;
    localparam logic [2:0] K_ACQREL = 3'd3;
    localparam logic [2:0] K_KBEGIN = 3'd4;
    localparam logic [2:0] K_KEND   = 3'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_kind = 3'd0;
    logic [CW-1:0] req_ctx = '0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b1;
    logic [IW-1:0] cmd_idx;
    logic          cmd_op;
    logic          wb_done = 1'b0;
    logic          inv_done = 1'b0;
    logic          done_valid;
    logic [CW-1:0] done_ctx;
    logic          issue_stall;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    l1_order_seq #(
        .NUM_BLOCKS (NB),
        .CTX_W      (CW),
        .KEND_DEPTH (DEPTH)
    ) i_l1_order_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_kind    (req_kind),
        .req_ctx     (req_ctx),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_idx     (cmd_idx),
        .cmd_op      (cmd_op),
        .wb_done     (wb_done),
        .inv_done    (inv_done),
        .done_valid  (done_valid),
        .done_ctx    (done_ctx),
        .issue_stall (issue_stall)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // takes a request; returns at the falling edge after the accepting edge
    task automatic send_req(input logic [2:0] kind, input logic [CW-1:0] ctx, input string req);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        req_ctx   = ctx;
        #1;
        check({req, " request taken"}, int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        req_kind  = K_PLAIN;
    endtask

    task automatic ready_is(input logic [2:0] kind, input int exp, input string req);
        req_kind = kind;
        #1;
        check({req, " req_ready"}, int'(req_ready), exp);
        req_kind = K_PLAIN;
    endtask

    // expects a full sweep starting at the current falling edge
    task automatic expect_walk(input logic op, input bit hold, input bit wb_mid, input string req);
        for (int i = 0; i < NB; i++) begin
            if (hold && i == 2) begin
                cmd_ready = 1'b0;
                for (int h = 0; h < 3; h++) begin
                    #1;
                    check({req, " held idx"}, int'(cmd_idx), 2);
                    check({req, " held valid"}, int'(cmd_valid), 1);
                    @(negedge clk);
                end
                cmd_ready = 1'b1;
            end
            wb_done = wb_mid && (i == 1 || i == 2);
            #1;
            check({req, " cmd_valid"}, int'(cmd_valid), 1);
            check({req, " cmd_idx"}, int'(cmd_idx), i);
            check({req, " cmd_op"}, int'(cmd_op), int'(op));
            if (i == 3) ready_is(K_KBEGIN, 0, "R5 during sweep");
            @(negedge clk);
        end
        wb_done = 1'b0;
    endtask

    task automatic pulse_wb(input int n);
        for (int i = 0; i < n; i++) begin
            wb_done = 1'b1;
            @(negedge clk);
        end
        wb_done = 1'b0;
    endtask

    task automatic pulse_inv(input int n);
        for (int i = 0; i < n; i++) begin
            inv_done = 1'b1;
            @(negedge clk);
        end
        inv_done = 1'b0;
    endtask

    task automatic idle_now(input string req);
        #1;
        check({req, " cmd_valid idle"}, int'(cmd_valid), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        check("R1 cmd_valid", int'(cmd_valid), 0);
        check("R1 done_valid", int'(done_valid), 0);
        check("R1 issue_stall", int'(issue_stall), 0);
        ready_is(K_REL, 1, "R1 nothing outstanding");
    endtask

    task automatic t_acquire();
        send_req(K_ACQ, 4'd0, "R2 acquire");
        expect_walk(1'b0, 1'b1, 1'b0, "R2 acquire");
        idle_now("R2");
        check("R10 no stall from invalidates", int'(issue_stall), 0);
        send_req(K_PLAIN, 4'd0, "R10 plain");
        idle_now("R10 plain causes no command");
    endtask

    task automatic t_inv_cap();
        send_req(K_ACQ, 4'd0, "R13 second acquire");
        expect_walk(1'b0, 1'b0, 1'b0, "R13 second acquire");
        ready_is(K_ACQ, 0, "R13 count above limit");
        ready_is(K_ACQREL, 0, "R13 acqrel above limit");
        pulse_inv(NB);
        ready_is(K_ACQ, 1, "R13 count at limit");
        pulse_inv(NB);
    endtask

    task automatic t_release_drain();
        send_req(K_REL, 4'd0, "R3 release");
        expect_walk(1'b1, 1'b0, 1'b0, "R3 release");
        #1;
        check("R3 stall after flush", int'(issue_stall), 1);
        ready_is(K_PLAIN, 0, "R6 plain in drain");
        ready_is(3'd7, 0, "R6 kind7 in drain");
        ready_is(K_ACQ, 0, "R6 acquire in drain");
        send_req(K_KBEGIN, 4'd0, "R7 kbegin, no invalidates");
        expect_walk(1'b0, 1'b0, 1'b0, "R7 kbegin sweep");
        send_req(K_KBEGIN, 4'd0, "R7 kbegin, invalidates out");
        idle_now("R7 no sweep");
        send_req(K_KEND, 4'd5, "R8 kend in drain");
        idle_now("R8 no sweep in drain");
        send_req(K_KEND, 4'd6, "R8 second kend in drain");
        #1;
        check("R9 no report in drain", int'(done_valid), 0);
        pulse_wb(NB - 1);
        #1;
        check("R11 one writeback left", int'(issue_stall), 1);
        check("R9 still held", int'(done_valid), 0);
        pulse_wb(1);
        #1;
        check("R6 stall released", int'(issue_stall), 0);
        check("R9 first report", int'(done_valid), 1);
        check("R9 first ctx", int'(done_ctx), 5);
        @(negedge clk);
        #1;
        check("R9 second report", int'(done_valid), 1);
        check("R9 second ctx", int'(done_ctx), 6);
        @(negedge clk);
        #1;
        check("R9 queue empty", int'(done_valid), 0);
        ready_is(K_PLAIN, 1, "R6 issue resumed");
        pulse_inv(NB);
    endtask

    task automatic t_acqrel();
        send_req(K_ACQREL, 4'd0, "R4 acqrel");
        expect_walk(1'b0, 1'b0, 1'b0, "R4 inval phase");
        expect_walk(1'b1, 1'b0, 1'b0, "R4 flush phase");
        idle_now("R4");
        check("R4 stall", int'(issue_stall), 1);
        pulse_wb(NB);
        pulse_inv(NB);
        #1;
        check("R4 drained", int'(issue_stall), 0);
    endtask

    task automatic t_concurrent();
        send_req(K_REL, 4'd0, "R11 release");
        expect_walk(1'b1, 1'b0, 1'b1, "R11 release");
        pulse_wb(NB - 3);
        #1;
        check("R11 net count one", int'(issue_stall), 1);
        pulse_wb(1);
        #1;
        check("R11 net count zero", int'(issue_stall), 0);
    endtask

    task automatic t_kend_queue();
        send_req(K_KEND, 4'd3, "R8 kend idle");
        expect_walk(1'b1, 1'b0, 1'b0, "R8 kend flush");
        #1;
        check("R8 not reported before drain", int'(done_valid), 0);
        send_req(K_KEND, 4'd9, "R12 fill");
        send_req(K_KEND, 4'd10, "R12 fill");
        send_req(K_KEND, 4'd11, "R12 fill");
        ready_is(K_KEND, 0, "R12 queue full");
        ready_is(K_KBEGIN, 1, "R7 kbegin still taken");
        pulse_wb(NB);
        for (int i = 0; i < DEPTH; i++) begin
            #1;
            check("R9 ordered report valid", int'(done_valid), 1);
            check("R9 ordered report ctx", int'(done_ctx), (i == 0) ? 3 : 8 + i);
            @(negedge clk);
        end
        #1;
        check("R9 reports end", int'(done_valid), 0);
        ready_is(K_KEND, 1, "R12 room again");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_acquire();
        t_inv_cap();
        t_release_drain();
        t_acqrel();
        t_concurrent();
        t_kend_queue();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

endmodule